// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block acts as a target on a two-wire serial bus and behaves like a 4096-byte serial EEPROM. It runs on a fast system clock, samples the bus clock and data lines, and pulls the data line low only through an open-drain enable output. A controller addresses it with a 7-bit device address and a direction bit. For writes, two address bytes and then data bytes follow, and every byte is acknowledged. For reads, bytes are shifted out from an internal pointer for as long as the controller keeps acknowledging.

Written bytes first go into a one-page staging buffer. A stop condition after write data starts a modelled programming period set by a counter. The staged bytes move into the internal register array during that period. Until the period ends the block answers nothing, not even its own address, so a controller can poll it to find out when the write is done. A start condition in any state abandons the transfer in progress and begins address decoding again.

Top module: `i2c_nvm_target`

## Requirements
- R1: While reset is asserted, and after it is released, the open-drain enable `sdaOe` is low until a transfer calls for the block to drive.
- R2: The block acknowledges only a device address whose upper four bits are 1010 and whose next three bits equal `devSel`, followed by a direction bit (0 = write, 1 = read). On a mismatch it leaves the data line released for every later bit until the next start condition.
- R3: A write transfer carries a high address byte and then a low address byte. Only the low four bits of the high byte are used, which gives a 12-bit pointer; the upper four bits have no effect.
- R4: A byte written to an address is returned when that address is read after the programming period.
- R5: A page write acknowledges every data byte. The low five pointer bits advance and wrap inside the 32-byte page, so a byte sent beyond the 32nd replaces the byte staged earlier at the same offset. All staged bytes land together.
- R6: A stop condition that ends a write transfer with at least one data byte starts a busy period of `BUSY_CYCLES` clocks. During that period a correctly addressed device byte gets no acknowledge. After it, the same byte is acknowledged.
- R7: During a sequential read the pointer advances by one after each byte and wraps from 0xFFF to 0x000.
- R8: When the controller leaves the acknowledge bit high after a read byte, the block stops driving and keeps the data line released until the next start or stop.
- R9: A start condition that arrives after write data but before a stop discards the staged bytes. No programming period follows, and the addressed location keeps its old value.
- R10: The acknowledge is held low for the whole high phase of the ninth clock pulse. The drive enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devSel | input | 3 | Strap value matched against device address bits 3..1 |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaOe | output | 1 | High to pull the data line low |

## Verification
The bench keeps the 12-bit address width and the 32-byte page, so both the page wrap and the pointer wrap at the top of the array can be reached. It shortens `BUSY_CYCLES` to 300 clocks, which is about two byte times on the modelled bus. That makes a poll issued right after a stop land inside the busy window, while a second poll a little later lands after it. Reads go back over locations written by byte writes, an over-long page write, writes on both sides of the array boundary and an aborted write. Each result is compared with a byte model that the bench keeps itself.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } busState_t;

  // Strobes from control to datapath, at most one datapath action per clock
  typedef struct packed {
    logic shiftRx;
    logic loadHi;
    logic loadLo;
    logic bufWrite;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/nvm_dpath.sv
module nvm_dpath
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  strobe_t    stb,
  output logic       sclLevel,
  output logic       sdaLevel,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startEv,
  output logic       stopEv,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       busy,
  output logic       bufAny
);

  localparam int PG_W     = $clog2(PAGE_BYTES);
  localparam int HI_W     = ADDR_W - 8;
  localparam int MEM_SIZE = 1 << ADDR_W;
  localparam int BC_W     = $clog2(BUSY_CYCLES + 1);

  // Bus sampling and condition detection
  logic sclQ, sdaQ, sclP, sdaP;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= scl;  sdaQ <= sdaIn; sclP <= sclQ; sdaP <= sdaQ;
    end
  end
  assign sclLevel = sclQ;
  assign sdaLevel = sdaQ;
  assign sclRise  = sclQ & ~sclP;
  assign sclFall  = ~sclQ & sclP;
  assign startEv  = sclQ & sclP & sdaP & ~sdaQ;
  assign stopEv   = sclQ & sclP & ~sdaP & sdaQ;

  // Receive shifter, transmit shifter, address pointer
  logic [7:0]        rxSh, txSh;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [MEM_SIZE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0; txSh <= '0; ptr <= '0;
    end else begin
      if (stb.shiftRx) rxSh <= {rxSh[6:0], sdaQ};
      if (stb.loadTx)  txSh <= mem[ptr];
      else if (stb.shiftTx) txSh <= {txSh[6:0], 1'b0};
      if (stb.loadHi)   ptr[ADDR_W-1:8] <= rxSh[HI_W-1:0];
      if (stb.loadLo)   ptr[7:0] <= rxSh;
      if (stb.bufWrite) ptr <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + PG_W'(1)};
      if (stb.loadTx)   ptr <= ptr + ADDR_W'(1);
    end
  end
  assign rxByte = rxSh;
  assign txMsb  = txSh[7];

  // Programming period: a counter that also walks the page slots
  logic [BC_W-1:0]          elapsed;
  logic [ADDR_W-PG_W-1:0]   commitPage;
  logic [PG_W-1:0]          slot;
  logic                     drainEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; elapsed <= '0; commitPage <= '0;
    end else if (stb.commit) begin
      busy <= 1'b1; elapsed <= '0; commitPage <= ptr[ADDR_W-1:PG_W];
    end else if (busy) begin
      elapsed <= elapsed + BC_W'(1);
      if (elapsed == BC_W'(BUSY_CYCLES - 1)) busy <= 1'b0;
    end
  end
  assign slot    = elapsed[PG_W-1:0];
  assign drainEn = busy && (elapsed < BC_W'(PAGE_BYTES));

  // Page staging buffer, one register slot per byte of the page
  logic [PAGE_BYTES-1:0] bufValid;
  logic [7:0]            bufData [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : gSlot
    logic       v;
    logic [7:0] d;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        v <= 1'b0; d <= '0;
      end else if (stb.loadLo) begin
        v <= 1'b0;
      end else if (stb.bufWrite && ptr[PG_W-1:0] == PG_W'(i)) begin
        v <= 1'b1; d <= rxSh;
      end else if (drainEn && slot == PG_W'(i)) begin
        v <= 1'b0;
      end
    end
    assign bufValid[i] = v;
    assign bufData[i]  = d;
  end
  assign bufAny = |bufValid;

  always_ff @(posedge clk) begin
    if (drainEn && bufValid[slot]) mem[{commitPage, slot}] <= bufData[slot];
  end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] devSel,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  input  logic       busy,
  input  logic       bufAny,
  output strobe_t    stb,
  output logic       ackDrive,
  output logic       txDrive,
  output logic       ctrlIdle
);

  busState_t  state;
  logic [3:0] bitCnt;
  logic       rdMode, mAck;
  logic       active, byteDone, ackEnd, devMatch;

  assign active   = (state != ST_IDLE);
  assign byteDone = active && sclFall && bitCnt == 4'd8;
  assign ackEnd   = active && sclFall && bitCnt == 4'd9;
  assign devMatch = (rxByte[7:1] == {4'b1010, devSel}) && !busy;
  assign ctrlIdle = !active;

  always_comb begin
    stb          = '0;
    stb.shiftRx  = active && sclRise && bitCnt < 4'd8;
    stb.loadHi   = byteDone && state == ST_AHI;
    stb.loadLo   = byteDone && state == ST_ALO;
    stb.bufWrite = byteDone && state == ST_WR;
    stb.loadTx   = ackEnd && ((state == ST_DEV && rdMode) || (state == ST_RD && mAck));
    stb.shiftTx  = active && sclFall && state == ST_RD && bitCnt != 4'd0 && bitCnt < 4'd8;
    stb.commit   = stopEv && state == ST_WR && bufAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; rdMode <= 1'b0; mAck <= 1'b0;
      ackDrive <= 1'b0; txDrive <= 1'b0;
    end else if (startEv) begin
      state <= ST_DEV; bitCnt <= '0; ackDrive <= 1'b0; txDrive <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE; bitCnt <= '0; ackDrive <= 1'b0; txDrive <= 1'b0;
    end else if (active) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
        else begin
          mAck   <= ~sdaLevel;
          bitCnt <= 4'd9;
        end
      end else if (byteDone) begin
        case (state)
          ST_DEV: if (devMatch) begin
                    ackDrive <= 1'b1; rdMode <= rxByte[0];
                  end else state <= ST_IDLE;
          ST_RD:  txDrive <= 1'b0;
          default: ackDrive <= 1'b1;
        endcase
      end else if (ackEnd) begin
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        case (state)
          ST_DEV: if (rdMode) begin
                    state <= ST_RD; txDrive <= 1'b1;
                  end else state <= ST_AHI;
          ST_AHI: state <= ST_ALO;
          ST_ALO: state <= ST_WR;
          ST_RD:  if (mAck) txDrive <= 1'b1;
                  else state <= ST_IDLE;
          default: state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_nvm_target.sv
module i2c_nvm_target
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] devSel,
  input  logic       scl,
  input  logic       sdaIn,
  output logic       sdaOe
);

  strobe_t    stb;
  logic       sclLevel, sdaLevel, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic       txMsb, busy, bufAny, ackDrive, txDrive, ctrlIdle;

  nvm_dpath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .stb(stb),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy), .bufAny(bufAny)
  );

  nvm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .devSel(devSel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv),
    .stopEv(stopEv), .rxByte(rxByte), .busy(busy), .bufAny(bufAny),
    .stb(stb), .ackDrive(ackDrive), .txDrive(txDrive), .ctrlIdle(ctrlIdle)
  );

  assign sdaOe = ackDrive | (txDrive & ~txMsb);

endmodule

// File: rtl/nvm_checker.sv
module nvm_checker
  import nvm_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdaOe,
  input logic    sclLevel,
  input logic    busy,
  input logic    ackDrive,
  input logic    ctrlIdle,
  input strobe_t stb
);

  // R1: reset leaves the line released
  a_r1_reset_released: assert property (@(posedge clk) !rstN |=> !sdaOe);

  // R10: the drive enable only moves while the bus clock is low
  a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

  // R6: silent for the whole programming period
  a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe && !ackDrive);

  // R6: a commit always opens a programming period
  a_r6_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> busy);

  // R2, R8: an idle controller never drives
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIdle |-> !sdaOe);

  // R5: datapath actions never collide
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadHi, stb.loadLo, stb.bufWrite, stb.loadTx, stb.shiftTx}));

endmodule

bind i2c_nvm_target nvm_checker uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLevel(sclLevel),
  .busy(busy), .ackDrive(ackDrive), .ctrlIdle(ctrlIdle), .stb(stb)
);

// File: tb/sim_i2c_nvm_target.sv
module sim_i2c_nvm_target;

  localparam int ADDR_W = 12;
  localparam int PAGE   = 32;
  localparam int BUSY   = 300;
  localparam int Q      = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mLow = 1'b0;
  logic [2:0] devSel = 3'b101;
  logic       sdaOe;
  logic       sdaBus;

  always #4 clk = ~clk;
  assign sdaBus = ~(mLow | sdaOe);

  i2c_nvm_target #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .devSel(devSel), .scl(scl), .sdaIn(sdaBus), .sdaOe(sdaOe)
  );

  int nChk = 0;
  int nFail = 0;
  logic [7:0] model [0:(1<<ADDR_W)-1];
  logic [7:0] expQ[$];
  logic [7:0] gotQ[$];
  string      reqQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tStart();
    mLow = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
    mLow = 1'b1; waitc(Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic tStop();
    mLow = 1'b1; waitc(Q); scl = 1'b1; waitc(Q); mLow = 1'b0; waitc(Q);
  endtask

  task automatic tWriteByte(input logic [7:0] b, output bit acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; waitc(Q); scl = 1'b1; waitc(2*Q); scl = 1'b0; waitc(Q);
    end
    mLow = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
    s1 = sdaBus; waitc(Q-1); s2 = sdaBus; waitc(1);
    scl = 1'b0; waitc(Q);
    check(s1 == s2, "R10 ack level steady through high phase", s2, s1);
    acked = !s1 && !s2;
  endtask

  task automatic tReadByte(input bit mAckLow, input bit push, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      mLow = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
      b = {b[6:0], sdaBus}; waitc(Q); scl = 1'b0; waitc(Q);
    end
    mLow = mAckLow; waitc(Q); scl = 1'b1; waitc(2*Q); scl = 1'b0; waitc(Q);
    mLow = 1'b0;
    if (push) gotQ.push_back(b);
  endtask

  task automatic tSetAddr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit a;
    tStart();
    tWriteByte({4'b1010, devSel, 1'b0}, a); check(a, {req, " device ack"}, a, 1);
    tWriteByte(hi, a); check(a, {req, " high addr ack"}, a, 1);
    tWriteByte(lo, a); check(a, {req, " low addr ack"}, a, 1);
  endtask

  // Writes a run of bytes: the model follows the page-wrap rule of R5
  task automatic tWrite(input int addr, input logic [7:0] hiTop, input logic [7:0] d[$], input string req);
    bit a;
    tSetAddr({hiTop[7:4], 4'(addr >> 8)}, 8'(addr), req);
    foreach (d[i]) begin
      tWriteByte(d[i], a); check(a, {req, " data ack"}, a, 1);
      model[(addr & ~(PAGE-1)) | ((addr + i) & (PAGE-1))] = d[i];
    end
    tStop();
    waitc(BUSY + 20);
  endtask

  task automatic tRead(input int addr, input int n, input string req);
    bit a;
    logic [7:0] b;
    tSetAddr({4'h0, 4'(addr >> 8)}, 8'(addr), req);
    tStart();
    tWriteByte({4'b1010, devSel, 1'b1}, a); check(a, {req, " read device ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(model[(addr + i) % (1 << ADDR_W)]);
      reqQ.push_back(req);
      tReadByte(i < n - 1, 1'b1, b);
    end
    tStop();
  endtask

  task automatic tPoll(input bit expAck, input string req);
    bit a;
    tStart();
    tWriteByte({4'b1010, devSel, 1'b0}, a);
    check(a == expAck, req, a, expAck);
    tStop();
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        logic [7:0] g, e;
        string r;
        g = gotQ.pop_front();
        if (expQ.size() == 0) begin
          check(1'b0, "scoreboard unexpected byte", g, 0);
        end else begin
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(g == e, {r, " read data"}, g, e);
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    logic [7:0] d[$];

    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = 8'h00;

    // R1: reset state
    waitc(3);
    check(sdaOe == 1'b0, "R1 released in reset", sdaOe, 0);
    rstN = 1'b1;
    waitc(5);
    check(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);

    // R2: wrong strap value, then a further byte must also go unanswered
    tStart();
    tWriteByte({4'b1010, 3'b100, 1'b0}, a);
    check(!a, "R2 mismatched address not acked", a, 0);
    tWriteByte(8'h00, a);
    check(!a, "R2 released after mismatch", a, 0);
    tStop();
    tStart();
    tWriteByte({4'b0110, devSel, 1'b0}, a);
    check(!a, "R2 wrong upper nibble not acked", a, 0);
    tStop();

    // R3, R4: byte write, upper nibble of high byte set and ignored
    d = '{8'h5A};
    begin
      tSetAddr(8'hF1, 8'h23, "R3");
      tWriteByte(8'h5A, a); check(a, "R4 data ack", a, 1);
      model[12'h123] = 8'h5A;
      tStop();
    end

    // R6: poll inside busy window, then after it
    tPoll(1'b0, "R6 no ack while programming");
    waitc(BUSY);
    tPoll(1'b1, "R6 ack after programming");

    // R3, R4: read back, then R8: extra clocks after master NACK stay released
    tSetAddr(8'h01, 8'h23, "R4");
    tStart();
    tWriteByte({4'b1010, devSel, 1'b1}, a); check(a, "R4 read device ack", a, 1);
    expQ.push_back(8'h5A); reqQ.push_back("R3 R4");
    tReadByte(1'b0, 1'b1, b);
    tReadByte(1'b0, 1'b0, b);
    check(b == 8'hFF, "R8 released after master NACK", b, 8'hFF);
    tStop();

    // R5: 36 bytes starting at offset 0x1C of page 0x040, wraps and overwrites
    d = {};
    for (int i = 0; i < 36; i++) d.push_back(8'(8'h30 + i));
    tWrite(12'h05C, 8'h00, d, "R5");
    tRead(12'h040, PAGE, "R5 R7");

    // R7: wrap of the pointer from the top of the array to zero
    tWrite(12'hFFE, 8'h00, '{8'hE1, 8'hE2}, "R7");
    tWrite(12'h000, 8'h00, '{8'h01, 8'h02}, "R7");
    tRead(12'hFFE, 4, "R7");

    // R9: abandon a write with a repeated start
    tWrite(12'h300, 8'h00, '{8'hC3}, "R9");
    tSetAddr(8'h03, 8'h00, "R9");
    tWriteByte(8'h11, a); check(a, "R9 data ack", a, 1);
    tWriteByte(8'h22, a); check(a, "R9 data ack", a, 1);
    tStart();
    tStop();
    tPoll(1'b1, "R9 no programming after abort");
    tRead(12'h300, 2, "R9");

    waitc(20);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule